// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice of the kind found in the arithmetic tiles of programmable logic. In its multiply mode it adds or subtracts two 25-bit two's complement operands, multiplies the 25-bit sum by an 18-bit two's complement multiplicand, sign-extends the product to 48 bits and adds it to, subtracts it from, or loads it into a 48-bit accumulator. A clear control zeroes the accumulator.

In its dual mode the 48-bit accumulator is split into two independent 24-bit lanes. Each lane adds, subtracts or loads its own 24-bit operand, and no carry passes from one lane to the other. A registered comparator checks the accumulator against a programmable 48-bit pattern under a 48-bit mask and raises a flag that lines up with the result.

Three register stages sit between the inputs and the result: operand and pre-adder, product, accumulator. The slice accepts a new operation on every clock cycle.

Top module: `prea_mac_slice`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `pat_match` is 0.
- R2: In multiply mode (`dual_mode`=0) with `acc_load`=1, `result` becomes the 48-bit sign extension of P×B. P is `opa`+`opd` when `pre_sub`=0 and `opa`−`opd` when `pre_sub`=1. All operands are signed two's complement.
- R3: The pre-adder sum P wraps within 25 bits. For example, 0xFFFFFF + 1 gives −2^24.
- R4: In multiply mode with `acc_load`=0, the product is added to the accumulator when `acc_sub`=0 and subtracted from it when `acc_sub`=1.
- R5: `acc_clr`=1 makes the accumulator 0 and takes priority over `acc_load` and every other control.
- R6: An operation presented at one rising edge shows on `result` just after the third rising edge, counting that edge as the first, and not earlier. Operations may be issued on consecutive cycles.
- R7: In dual mode (`dual_mode`=1) the low lane is bits 23:0 and takes its operand from `opa[23:0]`. The high lane is bits 47:24 and takes its operand from `opd[23:0]`. Each lane loads, adds or subtracts (selected by `acc_load` and `acc_sub`) modulo 2^24, with no carry between the lanes.
- R8: `pat_match` is 1 exactly when `((result ^ pat_value) & pat_mask) == 0`. A mask bit of 1 means that bit is compared. The flag is registered in the same cycle as `result`, using the pattern and mask that are present on that edge.
- R9: In multiply mode the accumulator wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_mode | input | 1 | 0 selects multiply, 1 selects two 24-bit lanes |
| pre_sub | input | 1 | 1 makes the pre-adder compute opa−opd |
| acc_sub | input | 1 | 1 subtracts the operand from the accumulator |
| acc_load | input | 1 | 1 replaces the accumulator with the operand |
| acc_clr | input | 1 | 1 zeroes the accumulator |
| opa | input | 25 | Pre-adder operand A; low lane operand in dual mode |
| opd | input | 25 | Pre-adder operand D; high lane operand in dual mode |
| opb | input | 18 | Signed multiplicand |
| pat_value | input | 48 | Pattern for the detector |
| pat_mask | input | 48 | Compare mask, 1 = compare the bit |
| result | output | 48 | Accumulator value |
| pat_match | output | 1 | Registered pattern-match flag |

## Verification
A wrong pre-adder or multiplier result, or a bad sign extension of the product, shows on `result` three cycles after the operation is issued. In accumulate mode the error then stays in every later sum. A carry that leaks between the dual lanes changes the upper 24 bits of `result` on the same cycle that the low lane wraps. A mis-timed match register makes `pat_match` disagree with `result` for one cycle whenever the accumulator moves across the pattern. Stage skew shows on streamed operations as a result that appears one cycle early or late.

// File: rtl/prea_mac_pkg.sv
package prea_mac_pkg;

  typedef enum logic {
    MODE_MUL  = 1'b0,
    MODE_DUAL = 1'b1
  } slice_mode_e;

  typedef struct packed {
    slice_mode_e mode;
    logic        sub;
    logic        load;
    logic        clr;
  } acc_ctl_t;

endpackage

// File: rtl/prea_stage.sv
module prea_stage
  import prea_mac_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48,
  parameter int L_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_in,
  input  logic [A_W-1:0] d_in,
  input  logic [B_W-1:0] b_in,
  input  logic           pre_sub,
  input  acc_ctl_t       ctl_in,
  output logic [A_W-1:0] pre_q,
  output logic [B_W-1:0] b_q,
  output logic [P_W-1:0] x_q,
  output acc_ctl_t       ctl_q
);
  localparam int NL = P_W / L_W;

  // Pre-adder: result wraps within the operand width
  function automatic logic [A_W-1:0] preadd(input logic [A_W-1:0] a,
                                            input logic [A_W-1:0] d,
                                            input logic           sub);
    return sub ? (a - d) : (a + d);
  endfunction

  logic [A_W-1:0] pre_nx;
  logic [P_W-1:0] x_nx;

  assign pre_nx = preadd(a_in, d_in, pre_sub);

  // Lane operands for dual mode: lane 0 from A, upper lanes from D
  for (genvar g = 0; g < NL; g++) begin : g_lane
    if (g == 0) begin : g_lo
      assign x_nx[g*L_W +: L_W] = a_in[L_W-1:0];
    end else begin : g_hi
      assign x_nx[g*L_W +: L_W] = d_in[L_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      b_q   <= '0;
      x_q   <= '0;
      ctl_q <= '0;
    end else begin
      pre_q <= pre_nx;
      b_q   <= b_in;
      x_q   <= x_nx;
      ctl_q <= ctl_in;
    end
  end

endmodule

// File: rtl/mul_stage.sv
module mul_stage
  import prea_mac_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] pre_in,
  input  logic [B_W-1:0] b_in,
  input  logic [P_W-1:0] x_in,
  input  acc_ctl_t       ctl_in,
  output logic [P_W-1:0] opnd_q,
  output acc_ctl_t       ctl_q
);
  localparam int PR_W  = A_W + B_W;
  localparam int EXT_W = P_W - PR_W + 1;

  // Signed product, formed at full accumulator width
  function automatic logic [P_W-1:0] mul_ext(input logic [A_W-1:0] p,
                                             input logic [B_W-1:0] b);
    logic [P_W-1:0] pe;
    logic [P_W-1:0] be;
    pe = {{(P_W-A_W){p[A_W-1]}}, p};
    be = {{(P_W-B_W){b[B_W-1]}}, b};
    return pe * be;
  endfunction

  logic [P_W-1:0]   prod_ext;
  logic [P_W-1:0]   opnd_nx;
  logic [EXT_W-1:0] prod_top;

  assign prod_ext = mul_ext(pre_in, b_in);
  assign opnd_nx  = (ctl_in.mode == MODE_DUAL) ? x_in : prod_ext;
  assign prod_top = opnd_q[P_W-1:PR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      ctl_q  <= '0;
    end else begin
      opnd_q <= opnd_nx;
      ctl_q  <= ctl_in;
    end
  end

  // R2
  prod_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.mode == MODE_MUL) |->
      ($countones(prod_top) == 0 || $countones(prod_top) == EXT_W));

endmodule

// File: rtl/acc_stage.sv
module acc_stage
  import prea_mac_pkg::*;
#(
  parameter int P_W = 48,
  parameter int L_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] opnd_in,
  input  acc_ctl_t       ctl_in,
  output logic [P_W-1:0] acc_nx,
  output logic [P_W-1:0] acc_q
);
  localparam int NL = P_W / L_W;

  function automatic logic [P_W-1:0] full_op(input logic [P_W-1:0] acc,
                                             input logic [P_W-1:0] x,
                                             input logic           sub,
                                             input logic           load);
    if (load) return x;
    return sub ? (acc - x) : (acc + x);
  endfunction

  function automatic logic [L_W-1:0] lane_op(input logic [L_W-1:0] acc,
                                             input logic [L_W-1:0] x,
                                             input logic           sub,
                                             input logic           load);
    if (load) return x;
    return sub ? (acc - x) : (acc + x);
  endfunction

  logic [P_W-1:0] mul_nx;
  logic [P_W-1:0] dual_nx;

  assign mul_nx = full_op(acc_q, opnd_in, ctl_in.sub, ctl_in.load);

  // Independent lane adders: no carry crosses a lane boundary
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign dual_nx[g*L_W +: L_W] = lane_op(acc_q[g*L_W +: L_W],
                                           opnd_in[g*L_W +: L_W],
                                           ctl_in.sub, ctl_in.load);
  end

  assign acc_nx = ctl_in.clr ? '0 :
                  (ctl_in.mode == MODE_DUAL) ? dual_nx : mul_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nx;
  end

  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_in.clr |=> (acc_q == '0));

  // R7
  lane_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_in.mode == MODE_DUAL && !ctl_in.clr && !ctl_in.load && !ctl_in.sub &&
     opnd_in[P_W-1:L_W] == '0)
      |=> (acc_q[P_W-1:L_W] == $past(acc_q[P_W-1:L_W])));

endmodule

// File: rtl/pat_det.sv
module pat_det #(
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] acc_nx,
  input  logic [P_W-1:0] acc_q,
  input  logic [P_W-1:0] pat,
  input  logic [P_W-1:0] mask,
  output logic           match_q
);
  function automatic logic hit(input logic [P_W-1:0] v,
                               input logic [P_W-1:0] p,
                               input logic [P_W-1:0] m);
    return ((v ^ p) & m) == '0;
  endfunction

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      match_q <= hit(acc_nx, pat, mask);
      seen_q  <= 1'b1;
    end
  end

  // R8
  match_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (match_q == ((((acc_q ^ $past(pat)) & $past(mask))) == '0)));

endmodule

// File: rtl/prea_mac_slice.sv
module prea_mac_slice
  import prea_mac_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48,
  parameter int L_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dual_mode,
  input  logic           pre_sub,
  input  logic           acc_sub,
  input  logic           acc_load,
  input  logic           acc_clr,
  input  logic [A_W-1:0] opa,
  input  logic [A_W-1:0] opd,
  input  logic [B_W-1:0] opb,
  input  logic [P_W-1:0] pat_value,
  input  logic [P_W-1:0] pat_mask,
  output logic [P_W-1:0] result,
  output logic           pat_match
);
  localparam int LAT = 3;

  acc_ctl_t       ctl_in;
  acc_ctl_t       ctl_s1;
  acc_ctl_t       ctl_s2;
  logic [A_W-1:0] pre_s1;
  logic [B_W-1:0] b_s1;
  logic [P_W-1:0] x_s1;
  logic [P_W-1:0] opnd_s2;
  logic [P_W-1:0] acc_nx;
  logic [P_W-1:0] acc_q;

  assign ctl_in.mode = dual_mode ? MODE_DUAL : MODE_MUL;
  assign ctl_in.sub  = acc_sub;
  assign ctl_in.load = acc_load;
  assign ctl_in.clr  = acc_clr;

  prea_stage #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .L_W(L_W)) u_prea (
    .clk(clk), .rst_n(rst_n), .a_in(opa), .d_in(opd), .b_in(opb),
    .pre_sub(pre_sub), .ctl_in(ctl_in),
    .pre_q(pre_s1), .b_q(b_s1), .x_q(x_s1), .ctl_q(ctl_s1)
  );

  mul_stage #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .pre_in(pre_s1), .b_in(b_s1), .x_in(x_s1),
    .ctl_in(ctl_s1), .opnd_q(opnd_s2), .ctl_q(ctl_s2)
  );

  acc_stage #(.P_W(P_W), .L_W(L_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .opnd_in(opnd_s2), .ctl_in(ctl_s2),
    .acc_nx(acc_nx), .acc_q(acc_q)
  );

  pat_det #(.P_W(P_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .acc_nx(acc_nx), .acc_q(acc_q),
    .pat(pat_value), .mask(pat_mask), .match_q(pat_match)
  );

  assign result = acc_q;

  // Checker-side state: edges seen since reset, saturating at the latency
  logic [1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               edges_q <= '0;
    else if (edges_q != 2'(LAT)) edges_q <= edges_q + 2'd1;
  end

  // Expected signed product for the end-to-end latency check
  function automatic logic [P_W-1:0] ref_prod(input logic [A_W-1:0] a,
                                              input logic [A_W-1:0] d,
                                              input logic [B_W-1:0] b,
                                              input logic           sub);
    logic signed [A_W-1:0] p;
    logic signed [P_W-1:0] r;
    p = sub ? (a - d) : (a + d);
    r = P_W'(p) * P_W'($signed(b));
    return r;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !pat_match));

  // R6
  clr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == 2'(LAT) && $past(acc_clr, 3)) |-> (result == '0));

  // R2 R6
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == 2'(LAT) && $past(acc_load && !acc_clr && !dual_mode, 3))
      |-> (result == ref_prod($past(opa, 3), $past(opd, 3),
                              $past(opb, 3), $past(pre_sub, 3))));

endmodule

// File: tb/prea_mac_slice_tb.sv
module prea_mac_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_mode = 1'b0, pre_sub = 1'b0, acc_sub = 1'b0;
  logic        acc_load = 1'b0, acc_clr = 1'b0;
  logic [24:0] opa = '0, opd = '0;
  logic [17:0] opb = '0;
  logic [47:0] pat_value = '0, pat_mask = '0;
  logic [47:0] result;
  logic        pat_match;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prea_mac_slice dut_i (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .pre_sub(pre_sub),
    .acc_sub(acc_sub), .acc_load(acc_load), .acc_clr(acc_clr),
    .opa(opa), .opd(opd), .opb(opb), .pat_value(pat_value),
    .pat_mask(pat_mask), .result(result), .pat_match(pat_match)
  );

  // Independent model of the signed product, using 64-bit integer math
  function automatic logic [47:0] exp_prod(input logic [24:0] a,
                                           input logic [24:0] d,
                                           input logic [17:0] b,
                                           input bit          sub);
    logic signed [24:0] p;
    longint             r;
    p = sub ? $signed(a - d) : $signed(a + d);
    r = longint'(p) * longint'($signed(b));
    return r[47:0];
  endfunction

  task automatic check(input string req, input logic [47:0] got,
                       input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic put(input bit dm, input bit ps, input bit as, input bit ld,
                     input bit cl, input logic [24:0] a, input logic [24:0] d,
                     input logic [17:0] b);
    dual_mode = dm; pre_sub = ps; acc_sub = as; acc_load = ld; acc_clr = cl;
    opa = a; opd = d; opb = b;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  // Issue one operation, then idle until its result is visible
  task automatic run_one(input bit dm, input bit ps, input bit as,
                         input bit ld, input bit cl, input logic [24:0] a,
                         input logic [24:0] d, input logic [17:0] b);
    @(negedge clk); put(dm, ps, as, ld, cl, a, d, b);
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 result in reset", result, '0);
    check("R1 match in reset", {47'd0, pat_match}, 48'd0);
  endtask

  task automatic t_preadd();
    run_one(0, 0, 0, 1, 0, 25'd1000, 25'd234, 18'h3FFFB);
    check("R2 (A+D)*B load", result, exp_prod(25'd1000, 25'd234, 18'h3FFFB, 0));
    run_one(0, 1, 0, 1, 0, 25'd100, 25'd300, 18'd7);
    check("R2 (A-D)*B load", result, 48'hFFFF_FFFF_FA88);
    run_one(0, 0, 0, 1, 0, 25'h1000000, 25'd0, 18'h20000);
    check("R2 extreme signed product", result, 48'h0200_0000_0000);
  endtask

  task automatic t_wrap25();
    run_one(0, 0, 0, 1, 0, 25'h0FFFFFF, 25'd1, 18'd1);
    check("R3 pre-adder wraps to -2^24", result, 48'hFFFF_FF00_0000);
  endtask

  task automatic t_accum();
    run_one(0, 0, 0, 1, 0, 25'd10, 25'd0, 18'd3);
    check("R4 load 30", result, 48'd30);
    run_one(0, 0, 0, 0, 0, 25'd5, 25'd5, 18'd4);
    check("R4 accumulate +40", result, 48'd70);
    run_one(0, 0, 1, 0, 0, 25'd2, 25'd0, 18'd3);
    check("R4 subtract 6", result, 48'd64);
  endtask

  task automatic t_clear();
    run_one(0, 0, 0, 1, 1, 25'd7, 25'd0, 18'd7);
    check("R5 clear beats load", result, 48'd0);
  endtask

  task automatic t_stream();
    run_one(0, 0, 0, 0, 1, '0, '0, '0);
    @(negedge clk); put(0, 0, 0, 1, 0, 25'd1, 25'd0, 18'd1);
    @(negedge clk); put(0, 0, 0, 0, 0, 25'd2, 25'd0, 18'd1);
    @(negedge clk); put(0, 0, 0, 0, 0, 25'd3, 25'd0, 18'd1);
    check("R6 no result after two edges", result, 48'd0);
    @(negedge clk); idle();
    check("R6 first result after three edges", result, 48'd1);
    @(negedge clk);
    check("R6 second streamed result", result, 48'd3);
    @(negedge clk);
    check("R6 third streamed result", result, 48'd6);
  endtask

  task automatic t_accwrap();
    @(negedge clk); put(0, 0, 0, 1, 0, 25'h1000000, 25'd0, 18'h20000);
    for (int i = 0; i < 63; i++) begin
      @(negedge clk); put(0, 0, 0, 0, 0, 25'h1000000, 25'd0, 18'h20000);
    end
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    check("R9 accumulator wraps mod 2^48", result, 48'h8000_0000_0000);
  endtask

  task automatic t_dual();
    run_one(1, 0, 0, 1, 0, 25'h0FFFFFF, 25'd1, 18'd0);
    check("R7 dual load", result, 48'h000001_FFFFFF);
    run_one(1, 0, 0, 0, 0, 25'd1, 25'd0, 18'd0);
    check("R7 low lane wraps, no carry", result, 48'h000001_000000);
    run_one(1, 0, 1, 0, 0, 25'd1, 25'd2, 18'd0);
    check("R7 dual subtract per lane", result, 48'hFFFFFF_FFFFFF);
  endtask

  task automatic t_pattern();
    @(negedge clk);
    pat_value = 48'h0000_1234_5678; pat_mask = 48'hFFFF_FFFF_FFFF;
    run_one(0, 0, 0, 1, 0, 25'h0012345, 25'd0, 18'd1);
    check("R8 result for pattern test", result, 48'h0000_0001_2345);
    check("R8 mismatch flag low", {47'd0, pat_match}, 48'd0);
    @(negedge clk);
    pat_value = 48'h0000_0001_2345;
    @(negedge clk);
    check("R8 full-mask match", {47'd0, pat_match}, 48'd1);
    pat_value = 48'h0000_0001_23AA; pat_mask = 48'hFFFF_FFFF_FF00;
    @(negedge clk);
    check("R8 masked low byte matches", {47'd0, pat_match}, 48'd1);
    pat_mask = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    check("R8 unmasked low byte differs", {47'd0, pat_match}, 48'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_preadd();
    t_wrap25();
    t_accum();
    t_clear();
    t_stream();
    t_accwrap();
    t_dual();
    t_pattern();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=done");
      summary();
      $finish;
    end
  end

endmodule